// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address of every beat of an SDRAM read or write burst. A controller supplies a starting column with a one-cycle start request. The sequencer then issues one column address per clock, with a valid flag and a first-beat strobe, and raises a done flag on the last beat. The burst length and the ordering come from a four-bit mode image that the block holds.

For fixed lengths of 2, 4 or 8, the burst never leaves the aligned block of columns that contains the start column. The low bits run either as a counter that wraps inside the block (sequential) or as the start bits XOR the beat number (interleaved). A full-page burst counts through the whole column space and wraps from the top column back to column 0. It runs until a terminate request ends it, so the controller can build a burst of any length.

The mode image can be rewritten only while every bank is idle. After an accepted write, new starts are refused for a fixed settle time. A start that arrives during a burst drops the remainder of that burst and begins the new one.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset there is no beat, `start_ready` is 1, `mode_err` is 0 and the mode is a length of 1 with sequential order.
- R2: The mode image decodes as follows. Bits [2:0] give the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Bit 3 gives the order: 0 is sequential and 1 is interleaved.
- R3: In sequential order with length L, beat n has the start column's bits above log2(L) unchanged, and its low bits equal (start low bits + n) mod L.
- R4: In interleaved order with length L, beat n has the upper bits unchanged and the low bits equal (start low bits XOR n).
- R5: An accepted start gives its first beat one clock later, with `burst_start` set. A fixed-length burst gives exactly L consecutive beats and sets `burst_done` only on the last one. For a length of 1, `burst_done` is set on the single beat.
- R6: A full-page burst is sequential over all 2^COL_W columns. It wraps from the highest column to 0 and keeps issuing beats until it is terminated or restarted.
- R7: While a burst is running, a `terminate` sampled on a clock edge without an accepted start leaves no beat after that edge and no `burst_done`.
- R8: A start accepted during a burst drops the rest of that burst, and the next beat is the first beat of the new burst.
- R9: A mode write (`mode_load`) takes effect only when `banks_idle` is 1. Otherwise the mode and `mode_err` are unchanged.
- R10: An accepted mode write drops `start_ready` for LOAD_WAIT cycles, and a start during that time is ignored.
- R11: Length codes 4, 5 and 6, and full page combined with interleaved order, set `mode_err` and behave as a length of 1 with sequential order. A valid mode write clears `mode_err`.
- R12: A burst keeps the mode that held at its start, even if the mode is rewritten while the burst runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Request to write the mode image |
| mode_word | input | 4 | New mode image: [2:0] length code, [3] order |
| banks_idle | input | 1 | All banks idle; enables mode writes |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | Starting column of the burst |
| terminate | input | 1 | End the running burst |
| start_ready | output | 1 | Starts are accepted (no settle time pending) |
| beat_valid | output | 1 | `beat_col` carries a beat |
| burst_start | output | 1 | First beat of a burst |
| burst_done | output | 1 | Last beat of a fixed-length burst |
| beat_col | output | COL_W | Column address of the current beat |
| mode_err | output | 1 | Held mode uses a reserved encoding |

States. The sequencer has three states: SEQ_IDLE, SEQ_BLOCK (fixed burst, more beats to come) and SEQ_PAGE (full-page burst). An accepted start moves any state to SEQ_BLOCK, to SEQ_PAGE, or back to SEQ_IDLE when the single beat is also the last. The last beat or a terminate returns the sequencer to SEQ_IDLE. The mode control has two states, MR_OPEN and MR_SETTLE. An accepted write enters MR_SETTLE or restarts it, and the last settle cycle returns it to MR_OPEN.

## Verification
A wrong beat counter or a wrong latched length shows up on the very next beat as a wrong column, or as a `burst_done` that comes early, late or never. The bench compares the outputs on every clock, so the error is caught in that cycle. A corrupted mode image or settle counter shows up as a wrong `mode_err` or `start_ready` right after the write. At the latest it shows up on the next burst, through its beat count and order. State left over from a burst that was terminated or restarted shows up as an extra or missing `beat_valid` one clock after the edge that ended the burst.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int MODE_W = 4;

    typedef struct packed {
        logic [1:0] lg;     // log2 of fixed length
        logic       ilv;    // interleaved order
        logic       page;   // full-page burst
        logic       bad;    // reserved encoding seen
    } burst_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_BLOCK,
        SEQ_PAGE
    } seq_state_e;

    typedef enum logic {
        MR_OPEN,
        MR_SETTLE
    } mr_state_e;

    function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] w);
        burst_cfg_t c;
        c = '0;
        unique case (w[2:0])
            3'd0:    c.lg = 2'd0;
            3'd1:    c.lg = 2'd1;
            3'd2:    c.lg = 2'd2;
            3'd3:    c.lg = 2'd3;
            3'd7:    c.page = 1'b1;
            default: c.bad = 1'b1;
        endcase
        if (!c.bad) begin
            c.ilv = w[3];
        end
        if (c.page && w[3]) begin
            c.page = 1'b0;
            c.ilv  = 1'b0;
            c.bad  = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/colseq_mode_ctl.sv
module colseq_mode_ctl
    import colseq_pkg::*;
#(
    parameter int LOAD_WAIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              banks_idle,
    input  logic [MODE_W-1:0] word,
    output burst_cfg_t        cfg,
    output logic              ready,
    output logic              err
);

    localparam int WW = (LOAD_WAIT < 1) ? 1 : $clog2(LOAD_WAIT + 1);
    localparam logic [WW-1:0] WAIT_INIT = WW'(LOAD_WAIT);

    mr_state_e     state_q, state_d;
    logic [WW-1:0] cnt_q;
    logic          accept;

    assign accept = load && banks_idle;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MR_OPEN: begin
                if (accept && (LOAD_WAIT > 0)) state_d = MR_SETTLE;
            end
            MR_SETTLE: begin
                if (accept)                state_d = MR_SETTLE;
                else if (cnt_q <= WW'(1)) state_d = MR_OPEN;
            end
            default: state_d = MR_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MR_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cfg   <= '0;
        end else begin
            if (accept) begin
                cnt_q <= WAIT_INIT;
                cfg   <= decode_mode(word);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - WW'(1);
            end
        end
    end

    assign ready = (state_q == MR_OPEN);
    assign err   = cfg.bad;

endmodule

// File: rtl/colseq_addr_calc.sv
module colseq_addr_calc
    import colseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] lin;
    logic [COL_W-1:0] xr;

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask[i] = cfg.page || (i < int'(cfg.lg));
    end

    assign lin = base + idx;
    assign xr  = base ^ idx;
    assign col = (base & ~mask) | ((cfg.ilv ? xr : lin) & mask);

endmodule

// File: rtl/colseq_fsm.sv
module colseq_fsm
    import colseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_ready,
    input  logic [COL_W-1:0] start_col,
    input  logic             terminate,
    input  burst_cfg_t       cfg_in,
    output logic [COL_W-1:0] nxt_base,
    output logic [COL_W-1:0] nxt_idx,
    output burst_cfg_t       nxt_cfg,
    output logic             beat_valid,
    output logic             burst_start,
    output logic             burst_done
);

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, idx_q;
    burst_cfg_t       cfg_q;
    logic             go, emit, strobe, last;
    logic [COL_W-1:0] lim;

    assign go = start && start_ready;

    for (genvar i = 0; i < COL_W; i++) begin : g_lim
        assign lim[i] = (i < int'(nxt_cfg.lg));
    end

    always_comb begin
        state_d  = state_q;
        nxt_base = base_q;
        nxt_idx  = idx_q;
        nxt_cfg  = cfg_q;
        emit     = 1'b0;
        strobe   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go) begin
                    nxt_base = start_col;
                    nxt_idx  = '0;
                    nxt_cfg  = cfg_in;
                    emit     = 1'b1;
                    strobe   = 1'b1;
                end
            end
            SEQ_BLOCK, SEQ_PAGE: begin
                if (go) begin
                    nxt_base = start_col;
                    nxt_idx  = '0;
                    nxt_cfg  = cfg_in;
                    emit     = 1'b1;
                    strobe   = 1'b1;
                end else if (terminate) begin
                    state_d = SEQ_IDLE;
                end else begin
                    nxt_idx = idx_q + COL_W'(1);
                    emit    = 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
        last = emit && !nxt_cfg.page && (nxt_idx == lim);
        if (emit) begin
            if (last)              state_d = SEQ_IDLE;
            else if (nxt_cfg.page) state_d = SEQ_PAGE;
            else                   state_d = SEQ_BLOCK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= nxt_base;
            idx_q   <= nxt_idx;
            cfg_q   <= nxt_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_valid  <= 1'b0;
            burst_start <= 1'b0;
            burst_done  <= 1'b0;
        end else begin
            beat_valid  <= emit;
            burst_start <= strobe;
            burst_done  <= last;
        end
    end

endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W     = 9,
    parameter int LOAD_WAIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [3:0]       mode_word,
    input  logic             banks_idle,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             terminate,
    output logic             start_ready,
    output logic             beat_valid,
    output logic             burst_start,
    output logic             burst_done,
    output logic [COL_W-1:0] beat_col,
    output logic             mode_err
);

    burst_cfg_t       cfg_cur, nxt_cfg;
    logic [COL_W-1:0] nxt_base, nxt_idx, nxt_col;

    colseq_mode_ctl #(.LOAD_WAIT(LOAD_WAIT)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (mode_load),
        .banks_idle (banks_idle),
        .word       (mode_word),
        .cfg        (cfg_cur),
        .ready      (start_ready),
        .err        (mode_err)
    );

    colseq_fsm #(.COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_ready (start_ready),
        .start_col   (start_col),
        .terminate   (terminate),
        .cfg_in      (cfg_cur),
        .nxt_base    (nxt_base),
        .nxt_idx     (nxt_idx),
        .nxt_cfg     (nxt_cfg),
        .beat_valid  (beat_valid),
        .burst_start (burst_start),
        .burst_done  (burst_done)
    );

    colseq_addr_calc #(.COL_W(COL_W)) u_addr (
        .base (nxt_base),
        .idx  (nxt_idx),
        .cfg  (nxt_cfg),
        .col  (nxt_col)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_col <= '0;
        else        beat_col <= nxt_col;
    end

endmodule

// File: rtl/colseq_checker.sv
module colseq_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic start_ready,
    input logic terminate,
    input logic mode_load,
    input logic banks_idle,
    input logic beat_valid,
    input logic burst_start,
    input logic burst_done,
    input logic mode_err
);

    assert_start_gives_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_ready) |=> (burst_start && beat_valid));

    assert_done_on_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> beat_valid);

    assert_strobe_on_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> beat_valid);

    assert_beats_continue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !burst_done && !terminate) |=> beat_valid);

    assert_terminate_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !burst_done && terminate && !(start && start_ready)) |=> !beat_valid);

    assert_busy_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && !banks_idle) |=> $stable(mode_err));

    assert_settle_after_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && banks_idle) |=> !start_ready);

endmodule

bind sdram_burst_colseq colseq_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_ready (start_ready),
    .terminate   (terminate),
    .mode_load   (mode_load),
    .banks_idle  (banks_idle),
    .beat_valid  (beat_valid),
    .burst_start (burst_start),
    .burst_done  (burst_done),
    .mode_err    (mode_err)
);

// File: tb/sdram_burst_colseq_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_colseq_tb_top;

    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;
    localparam int WAITC = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [3:0]       mode_word = '0;
    logic             banks_idle = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             terminate = 1'b0;
    logic             start_ready, beat_valid, burst_start, burst_done, mode_err;
    logic [COL_W-1:0] beat_col;

    always #4 clk = ~clk;

    sdram_burst_colseq #(.COL_W(COL_W), .LOAD_WAIT(WAITC)) dut_i (
        .clk (clk), .rst_n (rst_n), .mode_load (mode_load), .mode_word (mode_word),
        .banks_idle (banks_idle), .start (start), .start_col (start_col),
        .terminate (terminate), .start_ready (start_ready), .beat_valid (beat_valid),
        .burst_start (burst_start), .burst_done (burst_done), .beat_col (beat_col),
        .mode_err (mode_err)
    );

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_len, m_ilv, m_fp, m_err, m_wait;
    int act, b_base, b_n, b_len, b_ilv, b_fp;
    int e_valid, e_start, e_done, e_col;

    function automatic int ref_addr(int b, int n, int len, int ilv, int fp);
        int lo;
        if (fp != 0) return (b + n) % NCOL;
        lo = b % len;
        if (ilv != 0) return (b - lo) + (lo ^ n);
        return (b - lo) + ((lo + n) % len);
    endfunction

    task automatic chk(string what, int a, int e);
        checks++;
        if (a != e) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, a, e, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 1; m_ilv = 0; m_fp = 0; m_err = 0; m_wait = 0;
            act = 0; b_n = 0; b_base = 0; b_len = 1; b_ilv = 0; b_fp = 0;
            e_valid = 0; e_start = 0; e_done = 0; e_col = 0;
        end else begin
            if (start && m_wait == 0) begin
                b_base = int'(start_col); b_n = 0;
                b_len = m_len; b_ilv = m_ilv; b_fp = m_fp;
                e_valid = 1; e_start = 1;
                e_done = (b_fp == 0 && b_len == 1) ? 1 : 0;
                e_col = ref_addr(b_base, 0, b_len, b_ilv, b_fp);
                act = 1 - e_done;
            end else if (act != 0 && !terminate) begin
                b_n = b_n + 1;
                e_valid = 1; e_start = 0;
                e_done = (b_fp == 0 && b_n == b_len - 1) ? 1 : 0;
                e_col = ref_addr(b_base, b_n, b_len, b_ilv, b_fp);
                act = 1 - e_done;
            end else begin
                e_valid = 0; e_start = 0; e_done = 0; act = 0;
            end
            if (mode_load && banks_idle) begin
                int code;
                code = int'(mode_word[2:0]);
                m_wait = WAITC; m_err = 0; m_fp = 0; m_ilv = 0; m_len = 1;
                if (code <= 3) begin
                    m_len = 1 << code; m_ilv = int'(mode_word[3]);
                end else if (code == 7 && !mode_word[3]) begin
                    m_fp = 1;
                end else begin
                    m_err = 1;
                end
            end else if (m_wait > 0) begin
                m_wait = m_wait - 1;
            end
        end
        #2;
        if (!finished) begin
            chk("beat_valid", int'(beat_valid), e_valid);
            chk("burst_start", int'(burst_start), e_start);
            chk("burst_done", int'(burst_done), e_done);
            chk("start_ready", int'(start_ready), (m_wait == 0) ? 1 : 0);
            chk("mode_err", int'(mode_err), m_err);
            if (e_valid != 0) chk("beat_col", int'(beat_col), e_col);
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_mode(logic [3:0] w, logic idle);
        mode_load = 1'b1; mode_word = w; banks_idle = idle;
        cyc();
        mode_load = 1'b0; banks_idle = 1'b1;
    endtask

    task automatic go(int col);
        start = 1'b1; start_col = COL_W'(col);
        cyc();
        start = 1'b0;
    endtask

    task automatic stop_burst();
        terminate = 1'b1;
        cyc();
        terminate = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cur_req = "R1"; cyc(3);
        cur_req = "R5"; go(5); cyc(3);                        // single beat, done with it
        cur_req = "R10"; load_mode(4'b0010, 1'b1); go(9); cyc(4); // start during settle ignored
        cur_req = "R3"; go(13); cyc(6);                       // 13,14,15,12
        cur_req = "R4"; load_mode(4'b1011, 1'b1); cyc(4); go(501); cyc(10);
        cur_req = "R2"; load_mode(4'b0001, 1'b1); cyc(4); go(7); cyc(3);
        cur_req = "R3"; load_mode(4'b0011, 1'b1); cyc(4); go(258); cyc(10);
        cur_req = "R12"; go(100); cyc(2); load_mode(4'b0001, 1'b1); cyc(10);
        cur_req = "R8"; load_mode(4'b0011, 1'b1); cyc(4); go(40); cyc(3); go(200); cyc(10);
        cur_req = "R7"; go(60); cyc(2); stop_burst(); cyc(3);
        cur_req = "R6"; load_mode(4'b0111, 1'b1); cyc(4); go(510); cyc(5);
        cur_req = "R8"; go(3); cyc(3);
        cur_req = "R7"; stop_burst(); cyc(3);
        cur_req = "R9"; load_mode(4'b0010, 1'b1); cyc(4); load_mode(4'b0000, 1'b0); cyc(4);
        go(6); cyc(6);
        cur_req = "R11"; load_mode(4'b0101, 1'b1); cyc(4); go(77); cyc(3);
        load_mode(4'b1111, 1'b1); cyc(4); go(78); cyc(3);
        load_mode(4'b1000, 1'b1); cyc(4); go(79); cyc(3);
        cur_req = "R4"; load_mode(4'b1010, 1'b1); cyc(4); go(66); cyc(6);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule